// File: doc/BRIEF.md
# USB Frame Tick Recovery Timer

This block produces the 1 ms frame-start pulse of a full-speed USB device and keeps it running when start-of-frame packets are lost or corrupted. Every received start-of-frame strobe yields a pulse and loads the 11-bit frame number it carries. Between real strobes the block inserts synthetic pulses. After a single real strobe the spacing is the nominal count of one millisecond at 48 MHz. Once two real strobes have been seen, the spacing is the interval measured between the two most recent ones, clamped to a window around nominal.

The pulse drives the frame interrupt and the isochronous interval counters downstream. The frame-number register changes only on real strobes. The timer stays silent and returns to its idle state while either enable is low, while a bus reset is signalled, or while the device is suspended. It restarts only on the next real strobe.

Top module: `sof_recovery_timer`

## Requirements
- R1: After asynchronous reset, `frame_tick_o` is 0 and `frame_num_o` is 0.
- R2: While no start-of-frame strobe has been accepted since reset or since the last halt, `frame_tick_o` stays 0.
- R3: A strobe on `sof_valid_i` that is accepted in clock cycle k gives a one-cycle `frame_tick_o` in cycle k+1. In that same cycle `frame_num_o` holds the `sof_frame_i` value sampled in cycle k.
- R4: With exactly one strobe accepted since idle, synthetic ticks follow every CLK_PER_MS cycles (48000 by default), counted from the last tick.
- R5: After a second or later strobe, the synthetic period equals the number of cycles between the two most recent accepted strobes, if that number lies within the window of R6.
- R6: A measured interval below CLK_PER_MS-TOL_CYC or above CLK_PER_MS+TOL_CYC is replaced by the nearer bound of that window.
- R7: A synthetic tick leaves `frame_num_o` unchanged.
- R8: An accepted strobe restarts the period count at any time. The next synthetic tick comes one full period after that strobe's tick, and only one tick is produced when a strobe coincides with a synthetic tick.
- R9: While `usb_en_i` or `clk_en_i` is low, or `bus_reset_i` or `suspend_i` is high, no tick is produced and the timer returns to idle. After release, ticks resume only after a new strobe, and the period is then nominal again.
- R10: A strobe that arrives during a halt condition of R9 is ignored: it produces no tick and does not change `frame_num_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 48 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| usb_en_i | input | 1 | Function enable |
| clk_en_i | input | 1 | Clock-supply enable |
| sof_valid_i | input | 1 | One-cycle strobe for a received start-of-frame packet |
| sof_frame_i | input | 11 | Frame number carried by the packet |
| bus_reset_i | input | 1 | High while a bus reset is being received |
| suspend_i | input | 1 | High while the bus is suspended |
| frame_tick_o | output | 1 | One-cycle frame-start pulse, real or synthetic |
| frame_num_o | output | 11 | Frame number of the last real packet |

## Verification
A real strobe and a synthetic expiry can fall in the same cycle. The bench provokes this by timing a strobe to arrive exactly when the running period ends. It then judges that exactly one tick appears, that the tick carries the new frame number, and that the next expected tick is placed from the remeasured interval. The other overlap is a strobe arriving while suspended. That case is judged by the absence of any tick and by an unchanged frame number afterwards.

// File: rtl/sof_rec_pkg.sv
package sof_rec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_NOM   = 2'd1,
    ST_TRACK = 2'd2
  } rec_state_e;

endpackage

// File: rtl/sof_interval_meter.sv
module sof_interval_meter #(
  parameter int NOM   = 48000,
  parameter int MIN_P = 45600,
  parameter int MAX_P = 50400,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             sof_i,
  input  logic             first_i,
  output logic [CNT_W-1:0] period_o
);

  localparam logic [CNT_W-1:0] NOM_C = CNT_W'(NOM);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_P);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_P);
  localparam logic [CNT_W-1:0] SAT_C = CNT_W'(MAX_P + 1);

  logic [CNT_W-1:0] meas_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] clamped;

  always_comb begin
    if (meas_q < MIN_C)      clamped = MIN_C;
    else if (meas_q > MAX_C) clamped = MAX_C;
    else                     clamped = meas_q;
  end

  // meas_q saturates just above the window; anything beyond clamps the same
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meas_q   <= '0;
      period_q <= NOM_C;
    end else if (clear_i) begin
      meas_q   <= '0;
      period_q <= NOM_C;
    end else if (sof_i) begin
      meas_q   <= CNT_W'(1);
      period_q <= first_i ? NOM_C : clamped;
    end else if (meas_q < SAT_C) begin
      meas_q <= meas_q + CNT_W'(1);
    end
  end

  assign period_o = period_q;

  // R6
  period_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_q >= MIN_C) && (period_q <= MAX_C));

  // R5
  meas_adopt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && !clear_i && !first_i && meas_q >= MIN_C && meas_q <= MAX_C)
      |=> (period_q == $past(meas_q)));

endmodule

// File: rtl/sof_frame_gen.sv
module sof_frame_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             fire_o
);

  logic [CNT_W-1:0] fcnt_q;

  assign fire_o = run_i && !clear_i && !restart_i && (fcnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  fcnt_q <= '0;
    else if (clear_i)             fcnt_q <= '0;
    else if (restart_i || fire_o) fcnt_q <= CNT_W'(1);
    else if (run_i)               fcnt_q <= fcnt_q + CNT_W'(1);
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (fcnt_q <= period_i));

  // R8
  no_double_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);

endmodule

// File: rtl/sof_recovery_timer.sv
module sof_recovery_timer #(
  parameter int CLK_PER_MS = 48000,
  parameter int TOL_CYC    = 2400,
  parameter int FRAME_W    = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               usb_en_i,
  input  logic               clk_en_i,
  input  logic               sof_valid_i,
  input  logic [FRAME_W-1:0] sof_frame_i,
  input  logic               bus_reset_i,
  input  logic               suspend_i,
  output logic               frame_tick_o,
  output logic [FRAME_W-1:0] frame_num_o
);
  import sof_rec_pkg::*;

  localparam int MIN_P = CLK_PER_MS - TOL_CYC;
  localparam int MAX_P = CLK_PER_MS + TOL_CYC;
  localparam int CNT_W = $clog2(MAX_P + 2);

  rec_state_e         state_q;
  logic               halt;
  logic               sof_fire;
  logic               synth_fire;
  logic               tick_q;
  logic [FRAME_W-1:0] fnum_q;
  logic [CNT_W-1:0]   period;

  assign halt     = !usb_en_i || !clk_en_i || bus_reset_i || suspend_i;
  assign sof_fire = sof_valid_i && !halt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else if (halt) begin
      state_q <= ST_IDLE;
    end else if (sof_fire) begin
      state_q <= (state_q == ST_IDLE) ? ST_NOM : ST_TRACK;
    end
  end

  sof_interval_meter #(
    .NOM   (CLK_PER_MS),
    .MIN_P (MIN_P),
    .MAX_P (MAX_P),
    .CNT_W (CNT_W)
  ) u_meter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (halt),
    .sof_i    (sof_fire),
    .first_i  (state_q == ST_IDLE),
    .period_o (period)
  );

  sof_frame_gen #(
    .CNT_W (CNT_W)
  ) u_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (halt),
    .run_i     (state_q != ST_IDLE),
    .restart_i (sof_fire),
    .period_i  (period),
    .fire_o    (synth_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      fnum_q <= '0;
    end else begin
      tick_q <= !halt && (sof_fire || synth_fire);
      if (sof_fire) fnum_q <= sof_frame_i;
    end
  end

  assign frame_tick_o = tick_q;
  assign frame_num_o  = fnum_q;

  // R9
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |=> !frame_tick_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !sof_valid_i) |=> !frame_tick_o);

  // R3
  sof_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_fire |=> (frame_tick_o && frame_num_o == $past(sof_frame_i)));

  // R7
  num_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_fire |=> $stable(frame_num_o));

endmodule

// File: tb/sim_sof_recovery_timer.sv
module sim_sof_recovery_timer;

  localparam int P   = 100;
  localparam int TOL = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        usb_en = 1'b0;
  logic        clk_en = 1'b0;
  logic        sof_valid = 1'b0;
  logic [10:0] sof_frame = '0;
  logic        bus_reset = 1'b0;
  logic        suspend = 1'b0;
  logic        tick;
  logic [10:0] fnum;

  int unsigned cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  string       phase = "R2";

  int unsigned q_cyc[$];
  logic [10:0] q_fn[$];
  string       q_req[$];

  sof_recovery_timer #(.CLK_PER_MS(P), .TOL_CYC(TOL), .FRAME_W(11)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .usb_en_i(usb_en), .clk_en_i(clk_en),
    .sof_valid_i(sof_valid), .sof_frame_i(sof_frame),
    .bus_reset_i(bus_reset), .suspend_i(suspend),
    .frame_tick_o(tick), .frame_num_o(fnum)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push_exp(int unsigned c, logic [10:0] f, string r);
    q_cyc.push_back(c);
    q_fn.push_back(f);
    q_req.push_back(r);
  endtask

  task automatic wait_to(int unsigned c);
    @(negedge clk);
    while (cyc < c) @(negedge clk);
  endtask

  // strobe seen at clock edge c; its tick is sampled when cyc == c
  task automatic sof_at(int unsigned c, logic [10:0] f, string r);
    wait_to(c - 1);
    sof_valid = 1'b1;
    sof_frame = f;
    push_exp(c, f, r);
    @(negedge clk);
    sof_valid = 1'b0;
  endtask

  task automatic check(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  // monitor: pops expected ticks as the design produces them
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
        check(1'b0, q_req[0], "missing tick at cycle", 0, int'(q_cyc[0]));
        void'(q_cyc.pop_front()); void'(q_fn.pop_front()); void'(q_req.pop_front());
      end
      if (tick) begin
        if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
          check(fnum == q_fn[0], q_req[0], "frame number", int'(fnum), int'(q_fn[0]));
          void'(q_cyc.pop_front()); void'(q_fn.pop_front()); void'(q_req.pop_front());
        end else begin
          check(1'b0, phase, "unexpected tick at cycle", int'(cyc), -1);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned s1, s2, s3, s4, s5, s6, s7;
    #23;
    // R1 reset state
    check(tick == 1'b0, "R1", "tick in reset", int'(tick), 0);
    check(fnum == 11'd0, "R1", "frame number in reset", int'(fnum), 0);
    @(negedge clk);
    rst_n = 1'b1;
    usb_en = 1'b1;
    clk_en = 1'b1;
    // R2 idle: no ticks without a strobe
    phase = "R2";
    wait_to(cyc + 300);
    check(fnum == 11'd0, "R2", "frame number while idle", int'(fnum), 0);

    // R3 / R4 / R7: single strobe then nominal synthetic ticks
    phase = "R4";
    s1 = cyc + 10;
    sof_at(s1, 11'd5, "R3");
    push_exp(s1 + P, 11'd5, "R4");
    push_exp(s1 + 2 * P, 11'd5, "R7");

    // R8 / R6: strobe at arbitrary time, interval 250 clamps to P+TOL
    phase = "R6";
    s2 = s1 + 250;
    sof_at(s2, 11'd6, "R8");
    push_exp(s2 + P + TOL, 11'd6, "R6");
    s3 = s2 + 180;
    sof_at(s3, 11'd7, "R8");

    // R5: interval 95 inside window is adopted
    phase = "R5";
    s4 = s3 + 95;
    sof_at(s4, 11'd8, "R5");
    push_exp(s4 + 95, 11'd8, "R5");
    // R8 collision: strobe exactly on the synthetic expiry, one tick only
    s5 = s4 + 190;
    sof_at(s5, 11'd9, "R8");
    push_exp(s5 + P + TOL, 11'd9, "R6");

    // R9 / R10: suspend silences the timer and ignores strobes
    wait_to(s5 + P + TOL + 20);
    suspend = 1'b1;
    phase = "R9";
    wait_to(cyc + 150);
    sof_valid = 1'b1;
    sof_frame = 11'd10;
    @(negedge clk);
    sof_valid = 1'b0;
    phase = "R10";
    wait_to(cyc + 150);
    check(fnum == 11'd9, "R10", "frame number after strobe in suspend", int'(fnum), 9);
    suspend = 1'b0;
    phase = "R9";
    wait_to(cyc + 300);
    s6 = cyc + 5;
    sof_at(s6, 11'd12, "R9");
    push_exp(s6 + P, 11'd12, "R9");

    // R9 enable low
    wait_to(s6 + P + 30);
    clk_en = 1'b0;
    wait_to(cyc + 150);
    clk_en = 1'b1;
    wait_to(cyc + 250);

    // R9 bus reset, then nominal period again
    s7 = cyc + 5;
    sof_at(s7, 11'd20, "R9");
    push_exp(s7 + P, 11'd20, "R4");
    wait_to(s7 + P + 40);
    bus_reset = 1'b1;
    wait_to(cyc + 200);
    bus_reset = 1'b0;
    wait_to(cyc + 250);
    check(fnum == 11'd20, "R7", "frame number held after halts", int'(fnum), 20);
    check(q_cyc.size() == 0, "R9", "pending expected ticks", q_cyc.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule